// File: doc/BRIEF.md
# Reference-Gated Frequency Meter

This block reports the rate, in hertz, of a free-running fast counter. It has two sources for that number. The first is a closed-form value built from a crystal rate in kHz and a numerator/denominator ratio. When this value is usable, the block computes it with a sequential divider, and no measurement is needed. The second source is a timed window against a slow periodic reference tick. The fast count is latched on the first tick that follows arming, and the block then waits a fixed number of further ticks. The elapsed count is scaled up to a per-second rate.

A single start pulse launches either path. The result stays on `freq_o` and `done_o` stays high until the next accepted start. `busy_o` covers the whole computation, and a start pulse that arrives while it is high has no effect. With the default parameters the reference runs at 1000 Hz. The window is 1000/10 = 100 ticks long, so the count difference is multiplied by 10.

Top module: `freq_meter`

## Requirements
- R1: While `rst` is high and after it falls, `busy_o`, `done_o` and `freq_o` are all zero until a start is accepted.
- R2: A start pulse sampled while `busy_o` is low is accepted. After that clock edge `busy_o` is 1 and `done_o` is 0, whether or not a previous result was done.
- R3: A start pulse sampled while `busy_o` is high is ignored. The running computation finishes at the same edge and with the same result it would have had without the pulse.
- R4: When an accepted start sees a nonzero crystal kHz and a nonzero denominator, the result is floor(((kHz × 1000 × numerator) mod 2^64) / denominator). All products are taken in 64-bit arithmetic.
- R5: On the ratio path, `done_o` rises exactly 65 clock edges after the edge that accepted the start. This is one edge per quotient bit plus one.
- R6: When the crystal kHz is zero, or the denominator is zero, the block uses the tick-window measurement.
- R7: On the measurement path, the fast count is captured on the first reference tick sampled strictly after the accepting edge. A tick on the accepting edge itself does not count.
- R8: The window closes on the 100th reference tick after the capture tick, and `done_o` rises at that edge. The result is ((count at that edge − captured count) mod 2^64) × 10, so a counter wrap inside the window gives the correct rate.
- R9: Once `done_o` is high, further reference ticks do not change `freq_o`, `done_o` or `busy_o`.
- R10: `freq_o` changes only at the edge where `done_o` rises, and `busy_o` and `done_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request pulse |
| ref_tick_i | input | 1 | Reference tick, one cycle per tick |
| fast_cnt_i | input | 64 | Free-running fast counter value |
| xtal_khz_i | input | 32 | Crystal rate in kHz, zero when unknown |
| ratio_num_i | input | 32 | Ratio numerator |
| ratio_den_i | input | 32 | Ratio denominator |
| freq_o | output | 64 | Frequency result in Hz |
| done_o | output | 1 | Result valid |
| busy_o | output | 1 | Computation in progress |

## Verification
The bench numbers every rising clock edge. Each expected result carries the edge at which `done_o` must rise. On the ratio path this is the accepting edge plus 65. On the measurement path it is the 100th tick after the first tick strictly after the accepting edge, and the bench drives the ticks on a fixed grid, so it knows these edges in advance. The busy/done state is checked one edge after each accepted start. All outputs are sampled on the falling edge, so the edge counter already holds the number of the edge that produced them. A result that arrives one edge early or late fails even when its value is right.

// File: rtl/freq_meter_pkg.sv
package freq_meter_pkg;
  typedef enum logic [1:0] {
    FM_IDLE,
    FM_DIV,
    FM_MEAS
  } fm_state_e;
endpackage

// File: rtl/fm_seq_divider.sv
// Restoring divider, one quotient bit per cycle.
module fm_seq_divider #(
  parameter int NUM_W = 64,
  parameter int DEN_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic [NUM_W-1:0] quo_o,
  output logic             valid_o
);
  localparam int STEP_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0]  quo_q;
  logic [DEN_W-1:0]  rem_q;
  logic [DEN_W-1:0]  den_q;
  logic [STEP_W-1:0] step_q;
  logic              run_q;
  logic              valid_q;

  logic [DEN_W:0] rem_sh;
  logic [DEN_W:0] rem_sub;
  logic           fits;

  always_comb begin
    rem_sh  = {rem_q, quo_q[NUM_W-1]};
    fits    = rem_sh >= {1'b0, den_q};
    rem_sub = fits ? (rem_sh - {1'b0, den_q}) : rem_sh;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      quo_q   <= '0;
      rem_q   <= '0;
      den_q   <= '0;
      step_q  <= '0;
      run_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (load_i) begin
        quo_q  <= num_i;
        rem_q  <= '0;
        den_q  <= den_i;
        step_q <= STEP_W'(NUM_W);
        run_q  <= 1'b1;
      end else if (run_q) begin
        quo_q  <= {quo_q[NUM_W-2:0], fits};
        rem_q  <= rem_sub[DEN_W-1:0];
        step_q <= step_q - 1'b1;
        if (step_q == STEP_W'(1)) begin
          run_q   <= 1'b0;
          valid_q <= 1'b1;
        end
      end
    end
  end

  assign quo_o   = quo_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/fm_tick_window.sv
// Captures the fast count on the first tick after arming, then counts ticks.
module fm_tick_window #(
  parameter int CNT_W     = 64,
  parameter int WIN_TICKS = 100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm_i,
  input  logic             ref_tick_i,
  input  logic [CNT_W-1:0] fast_cnt_i,
  output logic             end_o,
  output logic [CNT_W-1:0] delta_o
);
  localparam int LEFT_W = $clog2(WIN_TICKS + 1);

  logic              wait_q;
  logic              count_q;
  logic [LEFT_W-1:0] left_q;
  logic [CNT_W-1:0]  cap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_q  <= 1'b0;
      count_q <= 1'b0;
      left_q  <= '0;
      cap_q   <= '0;
    end else if (arm_i) begin
      wait_q  <= 1'b1;
      count_q <= 1'b0;
    end else if (wait_q && ref_tick_i) begin
      cap_q   <= fast_cnt_i;
      left_q  <= LEFT_W'(WIN_TICKS);
      wait_q  <= 1'b0;
      count_q <= 1'b1;
    end else if (count_q && ref_tick_i) begin
      if (left_q == LEFT_W'(1)) count_q <= 1'b0;
      else                      left_q  <= left_q - 1'b1;
    end
  end

  assign end_o   = count_q && ref_tick_i && (left_q == LEFT_W'(1));
  assign delta_o = fast_cnt_i - cap_q;
endmodule

// File: rtl/freq_meter.sv
module freq_meter #(
  parameter int CNT_W     = 64,
  parameter int RATIO_W   = 32,
  parameter int REF_HZ    = 1000,
  parameter int WIN_DIV   = 10,
  parameter int KHZ_SCALE = 1000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic               ref_tick_i,
  input  logic [CNT_W-1:0]   fast_cnt_i,
  input  logic [RATIO_W-1:0] xtal_khz_i,
  input  logic [RATIO_W-1:0] ratio_num_i,
  input  logic [RATIO_W-1:0] ratio_den_i,
  output logic [CNT_W-1:0]   freq_o,
  output logic               done_o,
  output logic               busy_o
);
  import freq_meter_pkg::*;

  localparam int WIN_TICKS = REF_HZ / WIN_DIV;
  localparam int SCALE     = REF_HZ / WIN_TICKS;

  fm_state_e        state_q;
  logic             busy_q;
  logic             done_q;
  logic [CNT_W-1:0] freq_q;

  logic             accept;
  logic             use_ratio;
  logic [CNT_W-1:0] prod;
  logic [CNT_W-1:0] quo;
  logic             div_valid;
  logic             win_end;
  logic [CNT_W-1:0] delta;
  logic [CNT_W-1:0] scaled;

  assign accept    = start_i && !busy_q;
  assign use_ratio = (xtal_khz_i != '0) && (ratio_den_i != '0);
  assign prod      = CNT_W'(xtal_khz_i) * CNT_W'(KHZ_SCALE) * CNT_W'(ratio_num_i);
  assign scaled    = delta * CNT_W'(SCALE);

  fm_seq_divider #(
    .NUM_W(CNT_W),
    .DEN_W(RATIO_W)
  ) u_div (
    .clk    (clk),
    .rst    (rst),
    .load_i (accept && use_ratio),
    .num_i  (prod),
    .den_i  (ratio_den_i),
    .quo_o  (quo),
    .valid_o(div_valid)
  );

  fm_tick_window #(
    .CNT_W    (CNT_W),
    .WIN_TICKS(WIN_TICKS)
  ) u_win (
    .clk       (clk),
    .rst       (rst),
    .arm_i     (accept && !use_ratio),
    .ref_tick_i(ref_tick_i),
    .fast_cnt_i(fast_cnt_i),
    .end_o     (win_end),
    .delta_o   (delta)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= FM_IDLE;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      freq_q  <= '0;
    end else begin
      case (state_q)
        FM_IDLE: begin
          if (accept) begin
            busy_q  <= 1'b1;
            done_q  <= 1'b0;
            state_q <= use_ratio ? FM_DIV : FM_MEAS;
          end
        end
        FM_DIV: begin
          if (div_valid) begin
            freq_q  <= quo;
            done_q  <= 1'b1;
            busy_q  <= 1'b0;
            state_q <= FM_IDLE;
          end
        end
        FM_MEAS: begin
          if (win_end) begin
            freq_q  <= scaled;
            done_q  <= 1'b1;
            busy_q  <= 1'b0;
            state_q <= FM_IDLE;
          end
        end
        default: state_q <= FM_IDLE;
      endcase
    end
  end

  assign freq_o = freq_q;
  assign done_o = done_q;
  assign busy_o = busy_q;
endmodule

// File: rtl/freq_meter_chk.sv
module freq_meter_chk #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic [CNT_W-1:0] freq_o,
  input logic             done_o,
  input logic             busy_o
);
  // R10
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy_o && done_o));

  // R2
  start_arm_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> (busy_o && !done_o));

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> done_o);

  // R10
  freq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$rose(done_o) |-> $stable(freq_o));

  // R3
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> (busy_o || done_o));
endmodule

bind freq_meter freq_meter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .start_i(start_i),
  .freq_o (freq_o),
  .done_o (done_o),
  .busy_o (busy_o)
);

// File: tb/freq_meter_tb.sv
module freq_meter_tb;
  localparam int P = 20;

  typedef struct {
    logic [63:0] f;
    int          e;
    string       rq;
    string       rt;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        ref_tick = 1'b0;
  logic        tick_en = 1'b0;
  logic [63:0] fast_cnt = 64'hFFFF_FFFF_FFFF_F000;
  logic [63:0] inc = 64'd7;
  logic [31:0] khz = '0;
  logic [31:0] num = '0;
  logic [31:0] den = '0;
  logic [63:0] freq;
  logic        done;
  logic        busy;

  int   cyc = 0;
  int   total = 0;
  int   fails = 0;
  bit   finished = 1'b0;
  bit   prev_done = 1'b0;
  exp_t q[$];

  always #2 clk = ~clk;

  freq_meter u_dut (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start),
    .ref_tick_i (ref_tick),
    .fast_cnt_i (fast_cnt),
    .xtal_khz_i (khz),
    .ratio_num_i(num),
    .ratio_den_i(den),
    .freq_o     (freq),
    .done_o     (done),
    .busy_o     (busy)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // fast counter and reference tick grid: ticks land on edges that are multiples of P
  always @(negedge clk) begin
    fast_cnt <= fast_cnt + inc;
    ref_tick <= tick_en && (((cyc + 1) % P) == 0);
  end

  task automatic check64(string rq, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  // monitor: pops the expected item when done rises
  always @(negedge clk) begin
    if (!rst && done && !prev_done) begin
      if (q.size() == 0) begin
        total++; fails++;
        $display("FAIL R3: actual unexpected done at edge %0d expected none", cyc);
      end else begin
        exp_t it;
        it = q.pop_front();
        check64(it.rq, freq, it.f);
        check64(it.rt, 64'(cyc), 64'(it.e));
      end
    end
    prev_done <= done;
  end

  // driver: issues a start, pushes the expected result, checks the arm state
  task automatic launch(logic [31:0] k, logic [31:0] n, logic [31:0] d);
    int          se;
    int          t1;
    exp_t        it;
    @(negedge clk);
    khz = k; num = n; den = d;
    start = 1'b1;
    se = cyc + 1;
    if (k != 0 && d != 0) begin
      it.f  = (64'(k) * 64'd1000 * 64'(n)) / 64'(d);
      it.e  = se + 65;
      it.rq = "R4";
      it.rt = "R5";
    end else begin
      t1    = (se / P + 1) * P;
      it.f  = 64'd1000 * 64'(P) * inc;
      it.e  = t1 + 100 * P;
      it.rq = "R8";
      it.rt = "R7";
    end
    q.push_back(it);
    @(negedge clk);
    start = 1'b0;
    check64("R2", {62'd0, busy, done}, 64'd2);
  endtask

  task automatic wait_drain();
    for (int i = 0; i < 5000 && (q.size() != 0 || !done); i++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R1 during reset
    check64("R1", {62'd0, busy, done}, 64'd0);
    rst = 1'b0;
    tick_en = 1'b1;
    @(negedge clk);
    check64("R1", freq, 64'd0);
    check64("R1", {62'd0, busy, done}, 64'd0);

    // measurement with zero kHz, counter wraps inside the window (R6, R8)
    inc = 64'd7;
    launch(32'd0, 32'd5, 32'd3);
    repeat (500) @(negedge clk);
    // R3: start while busy, with ratio inputs that would pick the divider
    khz = 32'd24000; num = 32'd100; den = 32'd3;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check64("R3", {63'd0, busy}, 64'd1);
    wait_drain();

    // R9: ticks after done leave everything unchanged
    begin
      logic [63:0] held;
      held = freq;
      repeat (300) @(negedge clk);
      check64("R9", freq, held);
      check64("R9", {62'd0, busy, done}, 64'd1);
    end

    // R6: nonzero kHz but zero denominator forces measurement
    inc = 64'd3;
    launch(32'd24000, 32'd100, 32'd0);
    wait_drain();

    // ratio path, several values (R4, R5)
    launch(32'd24000, 32'd100, 32'd3);
    wait_drain();
    launch(32'd3000000, 32'd200, 32'd7);
    wait_drain();
    launch(32'd1, 32'd1, 32'd3);
    wait_drain();

    // measurement with a start phase off the tick grid (R7)
    inc = 64'd11;
    repeat (7) @(negedge clk);
    launch(32'd0, 32'd0, 32'd0);
    wait_drain();

    check64("R3", 64'(q.size()), 64'd0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule